// File: doc/BRIEF.md
# Chainable Counter Logic Cell

This block is a row of identical one-bit logic cells set up as a loadable binary counter. Each cell holds one register bit. Two three-input lookup functions sit in front of the register. The first forms the next count bit from the current bit, the count enable and the carry arriving from the bit below. The second forms the carry that passes to the bit above. A two-way select puts a parallel load word in place of the count value. An AND gate then forces the register input to zero for a synchronous clear. A per-bit cascade input, when the cascade path is on, is ANDed into the lookup result before the load and clear stages.

Each register is built from one flip-flop that has an asynchronous clear and nothing else. A per-bit parameter picks how that flip-flop is used. A plain bit uses the clear directly. A preset bit keeps the inverse of its value and inverts it again at the output, so clearing the flip-flop makes the bit read as one. A device-wide active-low reset clears every flip-flop and overrides all other controls. Because of the inversion, it leaves plain bits at zero and preset bits at one. The counter gives out the registered word, the unregistered word in front of the load stage, and the carry out of the top bit.

Top module: `cc_counter`

## Requirements
- R1: While `dev_rst_n` is low, `q` equals `PRESET_MASK` (8'h81 by default: bits 7 and 0 read one, the rest zero) at once, whatever the other inputs are.
- R2: With `sclr`, `sload`, `casc_en` low and `cnt_en` high, `q` goes up by one at each rising edge, and 8'hFF wraps to 8'h00.
- R3: With `sload` high and `sclr` low, `q` takes `load_val` at the next edge. This overrides counting and the cascade path.
- R4: With `sclr` high, `q` becomes 0 at the next edge, even when `sload` or `casc_en` is also high.
- R5: With `casc_en` high and `sclr`, `sload` low, `q` takes (`q` + `cnt_en`) AND `casc_in` at the next edge.
- R6: `carry_out` is high exactly when `cnt_en` is high and every bit of `q` is one. It is combinational.
- R7: `comb_out` is the unregistered value (`q` + `cnt_en`), ANDed with `casc_in` when `casc_en` is high. It is not affected by `sload` or `sclr`.
- R8: While `arst_clr` is high, plain bits (those with a zero in `PRESET_MASK`) read zero at once and stay zero across edges. Preset bits are left alone.
- R9: While `apre` is high, preset bits read one at once and stay one across edges. Plain bits are left alone.
- R10: With every control low and `cnt_en` low, `q` holds its value across an edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| dev_rst_n | input | 1 | Device-wide asynchronous reset, active low |
| arst_clr | input | 1 | Asynchronous clear for plain bits, active high |
| apre | input | 1 | Asynchronous preset for preset bits, active high |
| sclr | input | 1 | Synchronous clear |
| sload | input | 1 | Synchronous parallel load |
| load_val | input | WIDTH | Parallel load word |
| cnt_en | input | 1 | Count enable and carry into bit 0 |
| casc_en | input | 1 | Cascade path enable |
| casc_in | input | WIDTH | Per-bit cascade input |
| q | output | WIDTH | Registered counter word |
| comb_out | output | WIDTH | Unregistered lookup result after the cascade stage |
| carry_out | output | 1 | Carry out of the top bit |

## Verification
There are three kinds of result, each with its own timing. `comb_out` and `carry_out` are combinational, so they are due within the same cycle as the input change. The bench drives inputs at the falling edge and reads these two outputs one nanosecond later. The registered word passes through exactly one flip-flop, so it is due at the first rising edge after the inputs are driven, and it is compared at the falling edge that follows. The asynchronous clear, preset and device reset act without any clock. They are checked one nanosecond after they are raised, again after a rising edge while they are still held, and again after they are released.

// File: rtl/cc_pkg.sv
package cc_pkg;
  typedef enum logic {CELL_PLAIN = 1'b0, CELL_PRESET = 1'b1} cell_mode_e;
  // lookup index is {bit, enable, carry_in}
  localparam logic [7:0] SUM_MASK   = 8'h78; // bit ^ (enable & carry_in)
  localparam logic [7:0] CARRY_MASK = 8'h80; // bit & enable & carry_in
endpackage

// File: rtl/cc_lut3.sv
module cc_lut3 #(
  parameter logic [7:0] MASK = 8'h00
) (
  input  logic [2:0] sel,
  output logic       y
);
  assign y = MASK[sel];
endmodule

// File: rtl/cc_store.sv
module cc_store
  import cc_pkg::*;
#(
  parameter cell_mode_e MODE = CELL_PLAIN
) (
  input  logic clk,
  input  logic dev_rst_n,
  input  logic arst_clr,
  input  logic apre,
  input  logic d,
  output logic q
);
  logic held;
  logic aclr;

  generate
    if (MODE == CELL_PRESET) begin : g_preset
      // inverse is stored, so a cleared flop reads as one
      assign aclr = !dev_rst_n || apre;
      always_ff @(posedge clk or posedge aclr) begin
        if (aclr) held <= 1'b0;
        else      held <= ~d;
      end
      assign q = ~held;
    end else begin : g_plain
      assign aclr = !dev_rst_n || arst_clr;
      always_ff @(posedge clk or posedge aclr) begin
        if (aclr) held <= 1'b0;
        else      held <= d;
      end
      assign q = held;
    end
  endgenerate
endmodule

// File: rtl/cc_slice.sv
module cc_slice
  import cc_pkg::*;
#(
  parameter cell_mode_e MODE = CELL_PLAIN
) (
  input  logic clk,
  input  logic dev_rst_n,
  input  logic arst_clr,
  input  logic apre,
  input  logic sclr,
  input  logic sload,
  input  logic load_bit,
  input  logic casc_en,
  input  logic casc_bit,
  input  logic en,
  input  logic cin,
  output logic q,
  output logic comb,
  output logic cout
);
  logic       sum;
  logic       casc_val;
  logic       loaded;
  logic       d;
  logic [2:0] lut_sel;

  assign lut_sel = {q, en, cin};

  cc_lut3 #(.MASK(SUM_MASK))   u_sum   (.sel(lut_sel), .y(sum));
  cc_lut3 #(.MASK(CARRY_MASK)) u_carry (.sel(lut_sel), .y(cout));

  assign casc_val = casc_en ? (sum & casc_bit) : sum;
  assign comb     = casc_val;
  assign loaded   = sload ? load_bit : casc_val;
  assign d        = loaded & ~sclr;

  cc_store #(.MODE(MODE)) u_store (
    .clk(clk), .dev_rst_n(dev_rst_n), .arst_clr(arst_clr), .apre(apre),
    .d(d), .q(q)
  );

  logic async_any;
  assign async_any = !dev_rst_n || arst_clr || apre;

  p_clear_first_r4: assert property (@(posedge clk) disable iff (async_any)
    sclr |=> (q == 1'b0));

  p_load_bit_r3: assert property (@(posedge clk) disable iff (async_any)
    (sload && !sclr) |=> (q == $past(load_bit)));
endmodule

// File: rtl/cc_counter.sv
module cc_counter
  import cc_pkg::*;
#(
  parameter int               WIDTH       = 8,
  parameter logic [WIDTH-1:0] PRESET_MASK = 8'h81
) (
  input  logic             clk,
  input  logic             dev_rst_n,
  input  logic             arst_clr,
  input  logic             apre,
  input  logic             sclr,
  input  logic             sload,
  input  logic [WIDTH-1:0] load_val,
  input  logic             cnt_en,
  input  logic             casc_en,
  input  logic [WIDTH-1:0] casc_in,
  output logic [WIDTH-1:0] q,
  output logic [WIDTH-1:0] comb_out,
  output logic             carry_out
);
  localparam int CHAIN = WIDTH + 1;

  logic [CHAIN-1:0] carry;
  assign carry[0] = cnt_en;

  generate
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      localparam cell_mode_e BIT_MODE = PRESET_MASK[i] ? CELL_PRESET : CELL_PLAIN;
      cc_slice #(.MODE(BIT_MODE)) u_slice (
        .clk(clk), .dev_rst_n(dev_rst_n), .arst_clr(arst_clr), .apre(apre),
        .sclr(sclr), .sload(sload), .load_bit(load_val[i]),
        .casc_en(casc_en), .casc_bit(casc_in[i]),
        .en(cnt_en), .cin(carry[i]),
        .q(q[i]), .comb(comb_out[i]), .cout(carry[i+1])
      );
    end
  endgenerate

  assign carry_out = carry[WIDTH];

  logic async_any;
  assign async_any = !dev_rst_n || arst_clr || apre;

  p_dev_reset_r1: assert property (@(posedge clk)
    !dev_rst_n |-> (q == PRESET_MASK));

  p_count_step_r2: assert property (@(posedge clk) disable iff (async_any)
    (!sclr && !sload && !casc_en) |=>
      (q == WIDTH'($past(q) + {{(WIDTH-1){1'b0}}, $past(cnt_en)})));

  p_carry_top_r6: assert property (@(posedge clk) disable iff (!dev_rst_n)
    carry_out == (cnt_en && (&q)));

  p_preset_hold_r9: assert property (@(posedge clk) disable iff (!dev_rst_n)
    apre |-> ((q & PRESET_MASK) == PRESET_MASK));

  p_clear_plain_r8: assert property (@(posedge clk) disable iff (!dev_rst_n)
    arst_clr |-> ((q & ~PRESET_MASK) == '0));
endmodule

// File: tb/tb_cc_counter.sv
`timescale 1ns/1ps
module tb_cc_counter;
  localparam int         W    = 8;
  localparam logic [7:0] MASK = 8'h81;

  logic         clk = 1'b0;
  logic         dev_rst_n = 1'b1;
  logic         arst_clr = 1'b0, apre = 1'b0, sclr = 1'b0, sload = 1'b0;
  logic         cnt_en = 1'b0, casc_en = 1'b0;
  logic [W-1:0] load_val = '0, casc_in = '0;
  logic [W-1:0] q, comb_out;
  logic         carry_out;

  int checks = 0;
  int errors = 0;
  logic [W-1:0] m; // reference model of q

  always #10 clk = ~clk;

  cc_counter #(.WIDTH(W), .PRESET_MASK(MASK)) dut (
    .clk(clk), .dev_rst_n(dev_rst_n), .arst_clr(arst_clr), .apre(apre),
    .sclr(sclr), .sload(sload), .load_val(load_val), .cnt_en(cnt_en),
    .casc_en(casc_en), .casc_in(casc_in), .q(q), .comb_out(comb_out),
    .carry_out(carry_out)
  );

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle_inputs();
    sclr = 0; sload = 0; cnt_en = 0; casc_en = 0; load_val = '0; casc_in = '0;
  endtask

  // called at a falling edge; one clock cycle with the given controls
  task automatic cyc(input logic sc, input logic sl, input logic [W-1:0] lv,
                     input logic ce, input logic cs, input logic [W-1:0] ci);
    logic [W-1:0] cnt, cexp, nxt;
    string tag;
    sclr = sc; sload = sl; load_val = lv; cnt_en = ce; casc_en = cs; casc_in = ci;
    #1;
    cnt  = m + {{(W-1){1'b0}}, ce};
    cexp = cs ? (cnt & ci) : cnt;
    chk(cs ? "R7/R5 comb" : "R7 comb", comb_out, cexp);
    chk("R6 carry", {7'b0, carry_out}, {7'b0, (ce && (m == 8'hFF))});
    nxt = sc ? '0 : (sl ? lv : cexp);
    if (sc)      tag = "R4 clear";
    else if (sl) tag = "R3 load";
    else if (cs) tag = "R5 cascade";
    else if (ce) tag = "R2 count";
    else         tag = "R10 hold";
    @(posedge clk);
    m = nxt;
    @(negedge clk);
    chk(tag, q, m);
  endtask

  task automatic async_pulse(input bit use_clr);
    idle_inputs();
    if (use_clr) arst_clr = 1; else apre = 1;
    #1;
    m = use_clr ? (m & MASK) : (m | MASK);
    chk(use_clr ? "R8 async clear" : "R9 async preset", q, m);
    @(posedge clk);
    @(negedge clk);
    chk(use_clr ? "R8 held over edge" : "R9 held over edge", q, m);
    arst_clr = 0; apre = 0;
    #1;
    chk(use_clr ? "R8 after release" : "R9 after release", q, m);
    @(negedge clk);
  endtask

  task automatic dev_reset();
    sload = 1; load_val = 8'h5A; cnt_en = 1; sclr = 0; apre = 1; arst_clr = 1;
    dev_rst_n = 0;
    #1;
    chk("R1 immediate", q, MASK);
    @(posedge clk);
    @(negedge clk);
    chk("R1 over edge", q, MASK);
    apre = 0; arst_clr = 0; idle_inputs();
    dev_rst_n = 1;
    m = MASK;
    #1;
    chk("R1 release", q, MASK);
    @(negedge clk);
  endtask

  initial begin
    #3 dev_rst_n = 0;
    sload = 1; load_val = 8'h3C; cnt_en = 1;
    @(negedge clk);
    chk("R1 reset value", q, MASK);
    @(negedge clk);
    chk("R1 reset overrides load", q, MASK);
    idle_inputs();
    dev_rst_n = 1;
    m = MASK;
    @(negedge clk);

    for (int i = 0; i < 5; i++) cyc(0, 0, '0, 1, 0, '0);   // R2
    cyc(0, 1, 8'hFD, 0, 0, '0);                             // R3
    for (int i = 0; i < 4; i++) cyc(0, 0, '0, 1, 0, '0);   // R2 wrap FF->00
    chk("R2 wrap to zero", q, 8'h01);
    for (int i = 0; i < 3; i++) cyc(0, 0, '0, 0, 0, '0);   // R10
    cyc(0, 1, 8'hFF, 0, 0, '0);
    cyc(0, 0, '0, 0, 0, '0);                                // R6 carry low with en low
    cyc(0, 0, '0, 1, 0, '0);                                // R6 carry high at FF

    // every priority combination of clear, load, cascade, enable
    for (int k = 0; k < 16; k++) begin
      cyc(k[3], k[2], 8'(k * 37 + 5), k[0], k[1], 8'(8'hB6 ^ (k * 19)));
      cyc(0, 1, 8'(k * 53 + 7), 0, 0, '0);
    end

    for (int i = 0; i < 300; i++) begin
      logic [31:0] r;
      r = $urandom;
      cyc(r[3:0] == 4'h0, r[7:4] < 4'h3, r[15:8], r[16] | r[17], r[20:18] == 3'b0, r[31:24]);
    end

    cyc(0, 1, 8'h7E, 0, 0, '0);
    async_pulse(1);   // R8
    cyc(0, 1, 8'h00, 0, 0, '0);
    async_pulse(0);   // R9
    for (int i = 0; i < 3; i++) cyc(0, 0, '0, 1, 0, '0);
    cyc(0, 1, 8'h42, 0, 0, '0);
    dev_reset();      // R1
    for (int i = 0; i < 3; i++) cyc(0, 0, '0, 1, 0, '0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 20);
    errors++;
    checks++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule